// File: doc/BRIEF.md
# Tagged Receive Byte FIFO

This block sits between the bit receiver of a serial bus controller and the CPU. Each byte the receiver completes goes into a small queue together with three tags. The first tag tells whether the byte belongs to an address field or a data field. The second marks the byte that closes its field. The third is a 3-bit count of how many bits in the byte are meaningful. A field may run over any number of entries, and software counts the bytes it takes out.

The CPU sees the oldest entry through two read ports. The status port carries the tags plus two flags: a sticky flag saying a byte was lost, and a flag saying the queue holds something. The data port carries the byte itself. A data read strobe removes the oldest entry, so software reads status first and data second.

On entry, the block cleans up two kinds of byte. A byte that does not close its field is stored with a count of zero, which means all eight bits are valid. A closing byte with a count from 1 to 7 has every bit at or above that count cleared, so the valid bits sit right aligned from bit 0.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the queue is empty, the lost flag is clear, and both `stat_rd_q` and `data_rd_q` read 0.
- R2: An accepted byte and its tags come out in arrival order. `stat_rd_q` is laid out as follows: bit 7 is the lost flag, bit 6 is not-empty, bit 5 is the field type (1 means address, 0 means data), bit 4 is end-of-field, bit 3 is always 0, and bits 2:0 are the valid-bit count.
- R3: A byte offered while the queue is full, with no data read in the same cycle, is dropped, sets the lost flag, and leaves the stored entries unchanged.
- R4: A `data_rd` pulse on a non-empty queue removes the oldest entry. From the next cycle both ports show the following entry.
- R5: While the queue is empty, bits 5:0 of `stat_rd_q` and all of `data_rd_q` read 0. A `data_rd` pulse while empty leaves the queue contents and occupancy unchanged.
- R6: A `data_rd` pulse clears the lost flag, whether or not the queue is empty.
- R7: A byte offered in the same cycle as a data read is always accepted, even when the queue is full, and the occupancy stays the same.
- R8: A byte offered with end-of-field 0 is stored with a valid-bit count of 0, whatever count came with it.
- R9: A closing byte with count n from 1 to 7 is stored with bits 7 down to n cleared. A count of 0 keeps all eight bits.
- R10: The queue holds exactly DEPTH entries (default 8) before it refuses new bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receiver offers a byte this cycle |
| in_byte | input | 8 | Received byte, right aligned |
| in_addr | input | 1 | 1 means address field, 0 means data field |
| in_last | input | 1 | Byte closes its field |
| in_len | input | 3 | Valid-bit count; 0 means eight |
| data_rd | input | 1 | CPU data-port read strobe; removes the oldest entry |
| stat_rd_q | output | 8 | Status and tags of the oldest entry |
| data_rd_q | output | 8 | Byte of the oldest entry |

## Verification
Two events can land in the same cycle: a push from the receiver and a data read that removes an entry. The hardest version of this is a full queue, where the push must be stored in the slot being freed rather than dropped. The bench fills the queue to DEPTH and then pulses `in_valid` and `data_rd` together. It also overlaps the two strobes at random occupancies over a long random run. A reference queue in the bench applies the pop before the push at each edge. Its expected status and data are compared with the ports on every cycle, so a wrongly dropped byte, a changed occupancy or a spurious lost flag shows up in the following reads.

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_addr,
  input  logic       in_last,
  input  logic [2:0] in_len,
  input  logic       data_rd,
  output logic [7:0] stat_rd_q,
  output logic [7:0] data_rd_q
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [12:0]   mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic [CW-1:0] cnt;
  logic          lost;

  logic          nonempty, full, pop, wr_ok, drop;
  logic [2:0]    len_n;
  logic [7:0]    keep;
  logic [12:0]   front;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = cnt != '0;
  assign full     = cnt == CW'(DEPTH);
  assign pop      = data_rd & nonempty;
  assign wr_ok    = in_valid & (~full | pop);
  assign drop     = in_valid & ~wr_ok;
  assign len_n    = in_last ? in_len : 3'd0;
  assign keep     = (len_n == 3'd0) ? 8'hFF : ~(8'hFF << len_n);
  assign front    = mem[rp];

  assign stat_rd_q = {lost, nonempty,
                      nonempty ? {front[12], front[11], 1'b0, front[10:8]} : 6'd0};
  assign data_rd_q = nonempty ? front[7:0] : 8'd0;

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= {in_addr, in_last, len_n, in_byte & keep};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp   <= '0;
      wp   <= '0;
      cnt  <= '0;
      lost <= 1'b0;
    end else begin
      if (pop)   rp <= nxt(rp);
      if (wr_ok) wp <= nxt(wp);
      cnt <= cnt + CW'(wr_ok) - CW'(pop);
      if (drop)         lost <= 1'b1;
      else if (data_rd) lost <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_tag_fifo_chk.sv
module rx_tag_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          data_rd,
  input logic [CW-1:0] cnt,
  input logic [7:0]    stat_rd_q,
  input logic [7:0]    data_rd_q
);
  p_lost_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !data_rd && cnt == CW'(DEPTH)) |=> stat_rd_q[7]);

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_q[6] |-> (stat_rd_q[5:0] == 6'd0 && data_rd_q == 8'd0));

  p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !in_valid && cnt == '0) |=> cnt == '0);

  p_lost_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> !stat_rd_q[7]);

  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && data_rd && cnt != '0) |=> $stable(cnt));

  p_len_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_q[6] && !stat_rd_q[4]) |-> stat_rd_q[2:0] == 3'd0);

  p_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_q[6] && stat_rd_q[2:0] != 3'd0) |-> (data_rd_q >> stat_rd_q[2:0]) == 8'd0);

  p_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

bind rx_tag_fifo rx_tag_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_rd(data_rd),
  .cnt(cnt), .stat_rd_q(stat_rd_q), .data_rd_q(data_rd_q)
);

// File: tb/rx_tag_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_tag_fifo_tb_top;
  localparam int DEPTH = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_addr = 0, in_last = 0, data_rd = 0;
  logic [7:0] in_byte = 0;
  logic [2:0] in_len = 0;
  logic [7:0] stat_rd_q, data_rd_q;

  always #2 clk = ~clk;

  rx_tag_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_addr(in_addr), .in_last(in_last), .in_len(in_len), .data_rd(data_rd),
    .stat_rd_q(stat_rd_q), .data_rd_q(data_rd_q)
  );

  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  // reference: entries {addr,last,len[2:0],byte}
  logic [12:0] q[$];
  bit mlost = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      mlost = 0;
    end else begin
      bit p, acc;
      int l, b;
      p   = data_rd && q.size() > 0;
      acc = in_valid && (q.size() < DEPTH || p);
      if (p) void'(q.pop_front());
      if (acc) begin
        l = in_last ? int'(in_len) : 0;
        b = (l == 0) ? int'(in_byte) : (int'(in_byte) % (1 << l));
        q.push_back({in_addr, in_last, 3'(l), 8'(b)});
      end
      if (in_valid && !acc) mlost = 1;
      else if (data_rd) mlost = 0;
    end
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", r, act, exp);
    end
  endtask

  task automatic cmp();
    logic [7:0] es, ed;
    if (q.size() == 0) begin
      es = {mlost, 7'd0};
      ed = 8'd0;
    end else begin
      es = {mlost, 1'b1, q[0][12], q[0][11], 1'b0, q[0][10:8]};
      ed = q[0][7:0];
    end
    chk({req, " status"}, stat_rd_q, es);
    chk({req, " data"}, data_rd_q, ed);
  endtask

  task automatic step(bit v, logic [7:0] b, bit a, bit l, logic [2:0] n, bit r);
    @(negedge clk);
    cmp();
    in_valid = v; in_byte = b; in_addr = a; in_last = l; in_len = n; data_rd = r;
  endtask

  task automatic idle();
    step(0, 8'h00, 0, 0, 3'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status", stat_rd_q, 8'h00);
    chk("R1 data", data_rd_q, 8'h00);
    rst_n = 1;
    idle();

    // R2/R10: fill to DEPTH with mixed tags
    req = "R10";
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(8'h30 + i), i[0], (i % 3) == 2, 3'd0, 0);
    // R3: pushes while full are dropped, lost set
    req = "R3";
    for (int i = 0; i < 3; i++) step(1, 8'hEE, 1, 1, 3'd1, 0);
    idle(); idle();
    chk("R3 lost flag", stat_rd_q[7], 1'b1);
    chk("R3 oldest kept", data_rd_q, 8'h30);

    // R7: push and read together while full
    req = "R7";
    step(1, 8'h5A, 0, 1, 3'd0, 1);
    idle(); idle();
    chk("R7 front after pop", data_rd_q, 8'h31);
    chk("R6 lost cleared", stat_rd_q[7], 1'b0);

    // R4/R2: drain all in order
    req = "R4";
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 0, 3'd0, 1);
    idle(); idle();
    chk("R4 empty after drain", stat_rd_q[6], 1'b0);

    // R5: read when empty
    req = "R5";
    step(0, 8'h00, 0, 0, 3'd0, 1);
    step(0, 8'h00, 0, 0, 3'd0, 1);
    idle(); idle();
    chk("R5 empty data", data_rd_q, 8'h00);

    // R8: non-final byte with nonzero count stored with count 0
    req = "R8";
    step(1, 8'hFF, 1, 0, 3'd5, 0);
    idle(); idle();
    chk("R8 len forced 0", {5'd0, stat_rd_q[2:0]}, 8'h00);
    chk("R8 full byte", data_rd_q, 8'hFF);
    step(0, 8'h00, 0, 0, 3'd0, 1);

    // R9: partial final byte masked
    req = "R9";
    step(1, 8'hFF, 0, 1, 3'd3, 0);
    step(1, 8'hA5, 0, 1, 3'd0, 0);
    idle(); idle();
    chk("R9 masked byte", data_rd_q, 8'h07);
    chk("R9 status tags", stat_rd_q, 8'h53);
    step(0, 8'h00, 0, 0, 3'd0, 1);
    idle();
    chk("R9 len0 keeps 8", data_rd_q, 8'hA5);
    step(0, 8'h00, 0, 0, 3'd0, 1);

    // R7/R2 random overlap of push and pop
    req = "R7";
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, 8'($urandom), 1'($urandom), 1'($urandom),
           3'($urandom), ($urandom % 5) < 2);
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule